// File: doc/BRIEF.md
# UART Receive Holding Register

This block is the receive-side register logic of a memory-mapped serial port. It keeps one received byte until software reads it. While that byte is unread it withholds its ready signal from the deserializer, so a later byte can never overwrite a stored one. A level counter tracks how many bytes are stored. It drives the full, empty and idle flags, and it appears in a packed FIFO status word beside a transmit level that is supplied from outside.

A small state machine decides when input is accepted. It has two states. `S_VACANT` means nothing is stored and a byte may be taken. `S_HELD` means one byte waits for software. There are three transitions:

- `T_ACCEPT` moves from `S_VACANT` to `S_HELD` when a valid byte meets ready.
- `T_DRAIN` moves from `S_HELD` to `S_VACANT` when software reads the data register while receive is enabled and the level is above zero.
- `T_FLUSH` moves from either state to `S_VACANT` on a FIFO-control write that has the RX-reset bit set.

A control write also loads a receive watermark. A sticky interrupt bit rises when an accepted byte takes the level above that watermark.

Top module: `rxh_top`

## Requirements
- R1: `rx_ready` is 1 only when `rx_en` is 1 and `stat_full` is 0; otherwise it is 0.
- R2: In the cycle after a byte is accepted (`rx_valid` and `rx_ready` both 1), `stat_full` is 1, `stat_empty` and `stat_idle` are 0, and the RX-level field of `fifo_status` is 1.
- R3: While `stat_full` is 1, bytes offered on `rx_valid`/`rx_data` are ignored: a data read still returns the first byte and `stat_full` stays 1.
- R4: A read strobe to word address 0 (data) with `rx_en` 1 and level above zero takes the level to 0 on the next cycle. It clears `stat_full` and sets `stat_empty` and `stat_idle`. During the strobe, `rd_data[7:0]` is the stored byte and the upper bits are zero.
- R5: A data read while the level is zero, or while `rx_en` is 0, returns the stored byte and changes no flag and no level.
- R6: Word address 1 returns `fifo_status`. Bits 20:16 hold the low 5 bits of the receive level and bits 4:0 hold `tx_level`; every other bit is 0. Any address other than 0 and 1 reads as 0.
- R7: A FIFO-control write with bit 0 set forces the level to 0. On the next cycle it leaves `stat_full` 0, `stat_empty` and `stat_idle` 1, and `rx_wm_intr` 0. It wins over a byte accepted in the same cycle.
- R8: During and after reset, `stat_full` is 0, `stat_empty` and `stat_idle` are 1, `rx_wm_intr` is 0 and the level fields read 0.
- R9: Each FIFO-control write loads bits 3:1 as the RX watermark. On the cycle after an accept, `rx_wm_intr` becomes 1 if the new level exceeds the watermark. Once set, it stays 1 until an RX-reset write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Deserializer offers a byte |
| rx_data | input | 8 | Offered byte |
| rx_ready | output | 1 | Byte will be taken this cycle |
| rx_en | input | 1 | Receive-enable control bit |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | 3 | Word address of the read |
| rd_data | output | 32 | Read data (combinational from address) |
| fifo_ctrl_we | input | 1 | FIFO-control write strobe |
| fifo_ctrl_wdata | input | 4 | Bit 0 RX reset, bits 3:1 watermark |
| tx_level | input | 5 | Transmit level packed into the status word |
| stat_full | output | 1 | A byte is held |
| stat_empty | output | 1 | Level is zero |
| stat_idle | output | 1 | No received byte pending |
| fifo_status | output | 32 | Packed receive and transmit levels |
| rx_wm_intr | output | 1 | Sticky RX watermark interrupt state |

## Verification
`rx_ready` and `rd_data` are combinational, so the bench checks them 1 ns after it drives the inputs, before the next clock edge. The flags, the level fields and the interrupt each pass through one register. A read, accept or control write therefore shows on them one edge later, and the bench samples them 1 ns after that edge. Every byte value is swept through the sequence accept, ignored overwrite, disabled read, draining read and read at zero level. The transmit-level and watermark values are swept in full as well.

// File: rtl/rxh_pkg.sv
package rxh_pkg;
    typedef enum logic {
        S_VACANT = 1'b0,
        S_HELD   = 1'b1
    } rxh_state_e;

    localparam int unsigned ADDR_DATA      = 0;
    localparam int unsigned ADDR_FSTAT     = 1;
    localparam int unsigned RXLVL_LSB      = 16;
    localparam int unsigned TXLVL_LSB      = 0;
    localparam int unsigned LVL_REPORT_W   = 5;
    localparam int unsigned CTRL_RXRST_BIT = 0;
    localparam int unsigned CTRL_WM_LSB    = 1;
endpackage

// File: rtl/rxh_fsm.sv
module rxh_fsm
    import rxh_pkg::*;
#(
    parameter int unsigned LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_en,
    input  logic             drain_req,
    input  logic             flush,
    output logic             rx_ready,
    output logic             accept,
    output logic             full,
    output logic             empty,
    output logic             idle,
    output logic [LVL_W-1:0] level_q
);
    rxh_state_e state_q, state_d;
    logic       drain_ok;

    assign drain_ok = drain_req && rx_en && (level_q != '0);
    assign accept   = rx_valid && rx_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_VACANT;
        else        state_q <= state_d;
    end

    // transitions T_ACCEPT, T_DRAIN, T_FLUSH
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = S_VACANT;
        end else begin
            unique case (state_q)
                S_VACANT: if (accept) state_d = S_HELD;
                S_HELD:   if (drain_ok && level_q == LVL_W'(1)) state_d = S_VACANT;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            S_VACANT: begin rx_ready = rx_en; full = 1'b0; end
            S_HELD:   begin rx_ready = 1'b0;  full = 1'b1; end
        endcase
    end

    // level counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        level_q <= '0;
        else if (flush)    level_q <= '0;
        else if (accept)   level_q <= level_q + LVL_W'(1);
        else if (drain_ok) level_q <= level_q - LVL_W'(1);
    end

    assign empty = (level_q == '0);
    assign idle  = empty;
endmodule

// File: rtl/rxh_store.sv
module rxh_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned WM_W   = 3,
    parameter int unsigned LVL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              flush,
    input  logic              ctrl_we,
    input  logic [WM_W-1:0]   wm_wdata,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [LVL_W-1:0]  level_q,
    output logic [DATA_W-1:0] held_q,
    output logic              rx_wm_intr
);
    logic [WM_W-1:0]  wm_q;
    logic [LVL_W:0]   lvl_after;
    logic [LVL_W:0]   wm_ext;

    assign lvl_after = {1'b0, level_q} + (LVL_W+1)'(1);
    assign wm_ext    = (LVL_W+1)'(wm_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      held_q <= '0;
        else if (accept) held_q <= rx_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       wm_q <= '0;
        else if (ctrl_we) wm_q <= wm_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          rx_wm_intr <= 1'b0;
        else if (flush)                      rx_wm_intr <= 1'b0;
        else if (accept && lvl_after > wm_ext) rx_wm_intr <= 1'b1;
    end
endmodule

// File: rtl/rxh_rdmux.sv
module rxh_rdmux
    import rxh_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned RD_W   = 32
) (
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [DATA_W-1:0]       held,
    input  logic [LVL_REPORT_W-1:0] rx_lvl,
    input  logic [LVL_REPORT_W-1:0] tx_lvl,
    output logic [RD_W-1:0]         rd_data,
    output logic [RD_W-1:0]         fifo_status
);
    always_comb begin
        fifo_status = '0;
        fifo_status[RXLVL_LSB +: LVL_REPORT_W] = rx_lvl;
        fifo_status[TXLVL_LSB +: LVL_REPORT_W] = tx_lvl;
    end

    always_comb begin
        if (rd_addr == ADDR_W'(ADDR_DATA))
            rd_data = {{(RD_W-DATA_W){1'b0}}, held};
        else if (rd_addr == ADDR_W'(ADDR_FSTAT))
            rd_data = fifo_status;
        else
            rd_data = '0;
    end
endmodule

// File: rtl/rxh_top.sv
module rxh_top
    import rxh_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned RD_W   = 32,
    parameter int unsigned LVL_W  = 6,
    parameter int unsigned WM_W   = 3,
    localparam int unsigned CTRL_W = CTRL_WM_LSB + WM_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic [DATA_W-1:0]       rx_data,
    output logic                    rx_ready,
    input  logic                    rx_en,
    input  logic                    rd_stb,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [RD_W-1:0]         rd_data,
    input  logic                    fifo_ctrl_we,
    input  logic [CTRL_W-1:0]       fifo_ctrl_wdata,
    input  logic [LVL_REPORT_W-1:0] tx_level,
    output logic                    stat_full,
    output logic                    stat_empty,
    output logic                    stat_idle,
    output logic [RD_W-1:0]         fifo_status,
    output logic                    rx_wm_intr
);
    logic              drain_req;
    logic              flush;
    logic              accept;
    logic [LVL_W-1:0]  level_q;
    logic [DATA_W-1:0] held_q;

    assign drain_req = rd_stb && (rd_addr == ADDR_W'(ADDR_DATA));
    assign flush     = fifo_ctrl_we && fifo_ctrl_wdata[CTRL_RXRST_BIT];

    rxh_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_en     (rx_en),
        .drain_req (drain_req),
        .flush     (flush),
        .rx_ready  (rx_ready),
        .accept    (accept),
        .full      (stat_full),
        .empty     (stat_empty),
        .idle      (stat_idle),
        .level_q   (level_q)
    );

    rxh_store #(.DATA_W(DATA_W), .WM_W(WM_W), .LVL_W(LVL_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .flush      (flush),
        .ctrl_we    (fifo_ctrl_we),
        .wm_wdata   (fifo_ctrl_wdata[CTRL_W-1:CTRL_WM_LSB]),
        .rx_data    (rx_data),
        .level_q    (level_q),
        .held_q     (held_q),
        .rx_wm_intr (rx_wm_intr)
    );

    rxh_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_W(RD_W)) u_rdmux (
        .rd_addr     (rd_addr),
        .held        (held_q),
        .rx_lvl      (level_q[LVL_REPORT_W-1:0]),
        .tx_lvl      (tx_level),
        .rd_data     (rd_data),
        .fifo_status (fifo_status)
    );
endmodule

// File: rtl/rxh_checker.sv
module rxh_checker
    import rxh_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned RD_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              rx_en,
    input logic              rd_stb,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_byte,
    input logic              fifo_ctrl_we,
    input logic              ctrl_rxrst,
    input logic              stat_full,
    input logic              stat_empty,
    input logic              stat_idle,
    input logic [RD_W-1:0]   fifo_status,
    input logic              rx_wm_intr,
    input logic [DATA_W-1:0] held_q
);
    logic data_rd;
    logic flush;
    assign data_rd = rd_stb && (rd_addr == ADDR_W'(ADDR_DATA));
    assign flush   = fifo_ctrl_we && ctrl_rxrst;

    assert_no_ready_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stat_full |-> !rx_ready);

    assert_accept_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !flush) |=> (stat_full && !stat_empty && !stat_idle));

    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_full && !flush) |=> $stable(held_q));

    assert_drain_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rx_en && stat_full && !flush) |=> (stat_empty && !stat_full));

    assert_read_returns_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |-> (rd_byte == held_q));

    assert_disabled_read_inert_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_en && !flush) |=> $stable(stat_full));

    assert_status_zero_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_status[RD_W-1:21] == '0) && (fifo_status[15:5] == '0));

    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (stat_empty && stat_idle && !stat_full && !rx_wm_intr));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_full != stat_empty);

    assert_intr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wm_intr && !flush) |=> rx_wm_intr);
endmodule

bind rxh_top rxh_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RD_W(RD_W)) u_rxh_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_ready     (rx_ready),
    .rx_en        (rx_en),
    .rd_stb       (rd_stb),
    .rd_addr      (rd_addr),
    .rd_byte      (rd_data[DATA_W-1:0]),
    .fifo_ctrl_we (fifo_ctrl_we),
    .ctrl_rxrst   (fifo_ctrl_wdata[0]),
    .stat_full    (stat_full),
    .stat_empty   (stat_empty),
    .stat_idle    (stat_idle),
    .fifo_status  (fifo_status),
    .rx_wm_intr   (rx_wm_intr),
    .held_q       (held_q)
);

// File: tb/test_rxh_top.sv
`timescale 1ns/1ps
module test_rxh_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        rx_en = 1'b0;
    logic        rd_stb = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        fifo_ctrl_we = 1'b0;
    logic [3:0]  fifo_ctrl_wdata = '0;
    logic [4:0]  tx_level = '0;
    logic        stat_full, stat_empty, stat_idle;
    logic [31:0] fifo_status;
    logic        rx_wm_intr;

    int vectors = 0;
    int fails   = 0;

    always #4 clk = ~clk;

    rxh_top i_rxh_top (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .rx_en(rx_en), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .rd_data(rd_data), .fifo_ctrl_we(fifo_ctrl_we),
        .fifo_ctrl_wdata(fifo_ctrl_wdata), .tx_level(tx_level),
        .stat_full(stat_full), .stat_empty(stat_empty), .stat_idle(stat_idle),
        .fifo_status(fifo_status), .rx_wm_intr(rx_wm_intr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        rx_valid = 1'b0;
        rd_stb = 1'b0;
        fifo_ctrl_we = 1'b0;
    endtask

    // flags packed as {full, empty, idle}
    function automatic logic [31:0] flags();
        return {29'd0, stat_full, stat_empty, stat_idle};
    endfunction

    function automatic logic [31:0] fstat(input int rxl, input int txl);
        return (32'(rxl & 31) << 16) | 32'(txl & 31);
    endfunction

    task automatic ctrl_write(input logic [2:0] wm, input logic rst_bit);
        fifo_ctrl_we = 1'b1;
        fifo_ctrl_wdata = {wm, rst_bit};
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R8 flags in reset", flags(), 32'b011);
        chk("R8 intr in reset", {31'd0, rx_wm_intr}, 32'd0);
        chk("R8 status in reset", fifo_status, 32'd0);
        chk("R1 ready with rx_en=0", {31'd0, rx_ready}, 32'd0);
        rst_n = 1'b1;
        tick();
        chk("R8 flags after reset", flags(), 32'b011);
        rx_en = 1'b1;
        #1;
        chk("R1 ready when empty and enabled", {31'd0, rx_ready}, 32'd1);

        ctrl_write(3'd7, 1'b1);

        for (int b = 0; b < 256; b++) begin
            tx_level = 5'(b);
            rx_valid = 1'b1;
            rx_data = 8'(b);
            tick();
            chk("R2 flags after accept", flags(), 32'b100);
            chk("R1 ready while full", {31'd0, rx_ready}, 32'd0);
            rd_addr = 3'd1;
            #1;
            chk("R6 status read", rd_data, fstat(1, b));
            chk("R2 level field", fifo_status, fstat(1, b));

            rx_valid = 1'b1;
            rx_data = ~8'(b);
            tick();
            rd_addr = 3'd0;
            #1;
            chk("R3 byte kept when full", rd_data, 32'(b));
            chk("R3 still full", flags(), 32'b100);

            rx_en = 1'b0;
            rd_stb = 1'b1;
            tick();
            chk("R5 disabled read no change", flags(), 32'b100);
            chk("R5 disabled read level", fifo_status, fstat(1, b));
            rx_en = 1'b1;

            rd_stb = 1'b1;
            #1;
            chk("R4 read data", rd_data, 32'(b));
            tick();
            chk("R4 flags after drain", flags(), 32'b011);
            chk("R4 level after drain", fifo_status, fstat(0, b));

            rd_stb = 1'b1;
            tick();
            chk("R5 zero-level read flags", flags(), 32'b011);
            chk("R5 zero-level read data", rd_data, 32'(b));
            chk("R5 zero-level level", fifo_status, fstat(0, b));
        end

        for (int a = 2; a < 8; a++) begin
            rd_addr = 3'(a);
            #1;
            chk("R6 other address zero", rd_data, 32'd0);
        end
        rd_addr = 3'd0;

        for (int w = 0; w < 8; w++) begin
            ctrl_write(3'(w), 1'b1);
            chk("R7 intr cleared by rx reset", {31'd0, rx_wm_intr}, 32'd0);
            rx_valid = 1'b1;
            rx_data = 8'h5A;
            tick();
            chk("R9 intr after accept", {31'd0, rx_wm_intr}, (w < 1) ? 32'd1 : 32'd0);
            rd_stb = 1'b1;
            tick();
            chk("R9 intr sticky after drain", {31'd0, rx_wm_intr}, (w < 1) ? 32'd1 : 32'd0);
        end

        ctrl_write(3'd0, 1'b1);
        rx_valid = 1'b1;
        rx_data = 8'h33;
        tick();
        chk("R2 full before flush", flags(), 32'b100);
        ctrl_write(3'd0, 1'b1);
        chk("R7 flush while full", flags(), 32'b011);
        chk("R7 flush level", fifo_status[20:16], 32'd0);
        chk("R7 flush intr", {31'd0, rx_wm_intr}, 32'd0);
        #1;
        chk("R1 ready after flush", {31'd0, rx_ready}, 32'd1);

        rx_valid = 1'b1;
        rx_data = 8'hC3;
        fifo_ctrl_we = 1'b1;
        fifo_ctrl_wdata = 4'b0001;
        tick();
        chk("R7 flush wins over accept", flags(), 32'b011);

        rx_valid = 1'b1;
        rx_data = 8'h77;
        tick();
        chk("R2 full before reset", flags(), 32'b100);
        rst_n = 1'b0;
        #1;
        chk("R8 flags on reset", flags(), 32'b011);
        chk("R8 level on reset", fifo_status[20:16], 32'd0);
        tick();
        rst_n = 1'b1;
        tick();
        chk("R8 flags after release", flags(), 32'b011);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule